// File: doc/BRIEF.md
# Burst Peripheral Bus Timing Sequencer

This block turns one internal transfer request into the cycle-by-cycle strobes an external asynchronous memory bank expects. A request carries a line-aligned base address, a read/write flag, the byte lanes in use, a beat count and the index of the word wanted first. The block then drives the peripheral address, chip select (with its own drive enable so the pin can float), output enable, per-lane write or byte enables, a last-beat flag and a write-data drive enable. It advances through the beats in wrapping order, so the critical word goes out first.

All timing comes from a set of programmable fields that are sampled when a request is accepted. These fields are the chip-select delay, output-enable delay, first-beat wait, later-beat wait, write-enable on and off offsets, hold length, an enable-mode select and a keep-driven select for chip select. Before starting, the block checks that the fields are mutually consistent. If they are not, it refuses the request. It pulses a done flag once a transfer has fully ended.

Top module: `burst_strobe_seq`

## Requirements
- R1: Time is counted in cycles from c=0, the first cycle the address is driven, which is the cycle after acceptance. The active window lasts L = (FW+1) + (B-1)*(BW+1) cycles, where FW is the first-beat wait, BW is the later-beat wait and B is the beat count. Chip select `pb_cs_n` is low exactly for CD <= c < L, where CD is the chip-select delay, and `pb_cs_oe` is 1 whenever `pb_cs_n` is low.
- R2: During the hold period `pb_cs_oe` is 1 and `pb_cs_n` is 1. In the done cycle and in idle, `pb_cs_oe` equals the keep-driven select `cfg_cs_keep`. With hold 0 and keep-driven 0, chip select therefore goes from driven low straight to undriven.
- R3: On reads `pb_oe_n` is low exactly for CD+OD <= c < L, where OD is the output-enable delay. It is never low on writes.
- R4: Beat 0 occupies c = 0..FW. Beat k>=1 starts at c = (FW+1)+(k-1)*(BW+1). For each beat, `pb_addr` carries the base bits above the line, word index (crit+k) mod LINE_WORDS in the bits just above the byte bits, and zero byte bits.
- R5: In write-enable mode (`cfg_be_mode`=0), a write drives `pb_we_n` = ~lanes in beat 0 for CD+WN <= c < FW+1-WF, where WN is the write-enable on offset and WF is the write-enable off offset. Outside that range `pb_we_n` is all ones, and on reads it stays all ones.
- R6: In write-enable mode, a later beat with in-beat offset u drives `pb_we_n` = ~lanes for WN <= u < BW+1-WF.
- R7: In byte-enable mode (`cfg_be_mode`=1), `pb_we_n` = ~lanes for the whole active window on reads and writes alike, and WN and WF have no effect.
- R8: `pb_last` is 1 for every cycle of the final beat and 0 at all other times, including during hold.
- R9: Hold lasts TH cycles (0..7) right after the active window. In hold, `pb_addr_oe` stays 1, the address keeps the last beat's value, `pb_wdata_oe` stays 1 for writes, and `pb_cs_n`, `pb_oe_n` and `pb_we_n` are all inactive. `pb_wdata_oe` is 1 on writes from c=0 to the end of hold.
- R10: `cfg_err` is 1 when FW < CD+max(OD,WN)+WF or BW < WN+WF. While it is 1, `req_ready` is 0 and no transfer starts.
- R11: `xfer_done` is a one-cycle pulse at c = L+TH. `req_ready` returns at c = L+TH+1, and a request presented then starts with no dead cycle.
- R12: Timing fields changed after acceptance have no effect on the transfer in progress.
- R13: A beat count of 0 is treated as 1, and a count above LINE_WORDS is limited to LINE_WORDS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cs_dly | input | 2 | Chip-select delay CD |
| cfg_oe_dly | input | 2 | Output-enable delay OD |
| cfg_first_wait | input | 5 | First-beat wait FW |
| cfg_burst_wait | input | 3 | Later-beat wait BW |
| cfg_we_on | input | 2 | Write-enable on offset WN |
| cfg_we_off | input | 2 | Write-enable off offset WF |
| cfg_hold | input | 3 | Hold length TH |
| cfg_be_mode | input | 1 | 1: byte-enable mode, 0: write-enable mode |
| cfg_cs_keep | input | 1 | Keep chip select driven high when released |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Base address (line bits used) |
| req_lanes | input | LANES | Byte lanes in use, active high |
| req_beats | input | CNT_W | Beat count |
| req_crit | input | IDX_W | Word index of the first beat |
| pb_addr | output | ADDR_W | Peripheral address |
| pb_addr_oe | output | 1 | Address drive enable |
| pb_cs_n | output | 1 | Chip select, active low |
| pb_cs_oe | output | 1 | Chip-select drive enable |
| pb_oe_n | output | 1 | Output enable, active low |
| pb_we_n | output | LANES | Write/byte enables, active low |
| pb_last | output | 1 | Last-beat flag |
| pb_wdata_oe | output | 1 | Write-data drive enable |
| xfer_done | output | 1 | Transfer-complete pulse |
| cfg_err | output | 1 | Timing fields inconsistent |

## Verification
The hardest case to reach is a change of timing fields while a burst is already running. Here the strobes must keep the sampled values even though the live inputs disagree. The bench accepts a wrapping burst and rewrites the wait, delay and hold inputs one cycle after the start. It then compares every output, cycle by cycle, against a model that holds its own copy of the values in force at acceptance. Back-to-back requests issued in the first ready cycle after a done pulse cover the zero-gap restart.

// File: rtl/burst_seq_pkg.sv
// Shared field widths, the captured timing record and the phase encoding
// for the burst peripheral bus timing sequencer.
package burst_seq_pkg;
    localparam int CD_W = 2;
    localparam int OD_W = 2;
    localparam int FW_W = 5;
    localparam int BW_W = 3;
    localparam int WN_W = 2;
    localparam int WF_W = 2;
    localparam int TH_W = 3;
    localparam int SUM_W = FW_W + 1;

    typedef struct packed {
        logic [CD_W-1:0] cs_dly;
        logic [OD_W-1:0] oe_dly;
        logic [FW_W-1:0] first_wait;
        logic [BW_W-1:0] burst_wait;
        logic [WN_W-1:0] we_on;
        logic [WF_W-1:0] we_off;
        logic [TH_W-1:0] hold;
        logic            be_mode;
        logic            cs_keep;
    } timing_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACT  = 2'd1,
        PH_HOLD = 2'd2,
        PH_DONE = 2'd3
    } phase_e;
endpackage

// File: rtl/bseq_cfg_check.sv
// Consistency check of the timing fields.
// Assumes: fields are static while checked; purely combinational.
module bseq_cfg_check
    import burst_seq_pkg::*;
(
    input  timing_t cfg,
    output logic    bad
);
    logic [SUM_W-1:0] need_first;
    logic [SUM_W-1:0] need_burst;
    logic [SUM_W-1:0] widest;

    // Worst-case first-beat and later-beat demands against the waits.
    always_comb begin
        widest     = (cfg.oe_dly > cfg.we_on) ? SUM_W'(cfg.oe_dly) : SUM_W'(cfg.we_on);
        need_first = SUM_W'(cfg.cs_dly) + widest + SUM_W'(cfg.we_off);
        need_burst = SUM_W'(cfg.we_on) + SUM_W'(cfg.we_off);
        bad        = (SUM_W'(cfg.first_wait) < need_first) ||
                     (SUM_W'(cfg.burst_wait) < need_burst);
    end
endmodule

// File: rtl/bseq_phase_ctrl.sv
// Transfer phase machine: captures the request and timing fields on
// acceptance and walks active beats, hold cycles and the done cycle.
// Assumes: start is only raised in PH_IDLE with consistent fields.
module bseq_phase_ctrl
    import burst_seq_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W     = $clog2(LINE_WORDS),
    localparam int CNT_W     = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  timing_t          cfg_in,
    input  logic             write_in,
    input  logic [LANES-1:0] lanes_in,
    input  logic [CNT_W-1:0] beats_in,
    output phase_e           phase,
    output logic [IDX_W-1:0] beat,
    output logic [FW_W-1:0]  off,
    output logic             first,
    output logic             on_last,
    output timing_t          cfg_q,
    output logic             write_q,
    output logic [LANES-1:0] lanes_q
);
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] last_idx_in;
    logic [TH_W-1:0]  hcnt;
    logic [FW_W-1:0]  beat_end;

    // Clamp the requested beat count into 1..LINE_WORDS, as a last index.
    always_comb begin
        if (beats_in == '0)
            last_idx_in = '0;
        else if (beats_in > CNT_W'(LINE_WORDS))
            last_idx_in = IDX_W'(LINE_WORDS - 1);
        else
            last_idx_in = IDX_W'(beats_in - CNT_W'(1));
    end

    // Final offset of the current beat.
    always_comb begin
        beat_end = first ? cfg_q.first_wait : FW_W'(cfg_q.burst_wait);
    end

    assign first   = (beat == '0);
    assign on_last = (beat == last_idx);

    // Phase, beat, offset and hold counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            beat     <= '0;
            off      <= '0;
            hcnt     <= '0;
            last_idx <= '0;
            cfg_q    <= '0;
            write_q  <= 1'b0;
            lanes_q  <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase    <= PH_ACT;
                        beat     <= '0;
                        off      <= '0;
                        last_idx <= last_idx_in;
                        cfg_q    <= cfg_in;
                        write_q  <= write_in;
                        lanes_q  <= lanes_in;
                    end
                end
                PH_ACT: begin
                    if (off == beat_end) begin
                        off <= '0;
                        if (beat == last_idx) begin
                            hcnt  <= '0;
                            phase <= (cfg_q.hold != '0) ? PH_HOLD : PH_DONE;
                        end else begin
                            beat <= beat + IDX_W'(1);
                        end
                    end else begin
                        off <= off + FW_W'(1);
                    end
                end
                PH_HOLD: begin
                    if (hcnt == cfg_q.hold - TH_W'(1))
                        phase <= PH_DONE;
                    else
                        hcnt <= hcnt + TH_W'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACT) |-> (beat <= last_idx)); // R4
    AST_HOLD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) |-> (hcnt < cfg_q.hold)); // R9
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE) |=> (phase == PH_IDLE)); // R11
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACT) |=> ((phase == PH_IDLE) || $stable(cfg_q))); // R12
endmodule

// File: rtl/bseq_addr_gen.sv
// Wrapping address generator: keeps the line base and critical word and
// forms each beat's word address, critical word first.
// Assumes: LINE_WORDS and LANES are powers of two.
module bseq_addr_gen
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LANES      = 4,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W     = $clog2(LINE_WORDS),
    localparam int BYTE_BITS = $clog2(LANES),
    localparam int LINE_LSB  = IDX_W + BYTE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [IDX_W-1:0]  crit_in,
    input  phase_e            phase,
    input  logic [IDX_W-1:0]  beat,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_oe
);
    logic [ADDR_W-1:LINE_LSB] line_q;
    logic [IDX_W-1:0]         crit_q;
    logic [IDX_W-1:0]         word;

    // Capture the line and critical word when a transfer is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            crit_q <= '0;
        end else if (start) begin
            line_q <= base_in[ADDR_W-1:LINE_LSB];
            crit_q <= crit_in;
        end
    end

    // Word index wraps within the line.
    always_comb begin
        word    = crit_q + beat;
        addr    = {line_q, word, {BYTE_BITS{1'b0}}};
        addr_oe = (phase == PH_ACT) || (phase == PH_HOLD);
    end

    AST_ADDR_STEADY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) |-> $stable(addr)); // R9
endmodule

// File: rtl/bseq_strobe_gen.sv
// Strobe decoder: turns phase, beat and in-beat offset into chip select,
// output enable, write/byte enables, last flag and data drive enable.
// Assumes: captured fields passed the consistency check.
module bseq_strobe_gen
    import burst_seq_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           phase,
    input  logic [FW_W-1:0]  off,
    input  logic             first,
    input  logic             on_last,
    input  timing_t          cfg_q,
    input  logic             keep_live,
    input  logic             write_q,
    input  logic [LANES-1:0] lanes_q,
    output logic             cs_n,
    output logic             cs_oe,
    output logic             oe_n,
    output logic [LANES-1:0] we_n,
    output logic             last,
    output logic             wdata_oe
);
    logic             active;
    logic             holding;
    logic [SUM_W-1:0] u;
    logic [SUM_W-1:0] cs_at;
    logic [SUM_W-1:0] oe_at;
    logic [SUM_W-1:0] we_at;
    logic [SUM_W-1:0] we_end;
    logic             we_win;
    logic             we_low;

    // Phase decode and in-beat offset thresholds.
    always_comb begin
        active  = (phase == PH_ACT);
        holding = (phase == PH_HOLD);
        u       = SUM_W'(off);
        cs_at   = first ? SUM_W'(cfg_q.cs_dly) : '0;
        oe_at   = first ? SUM_W'(cfg_q.cs_dly) + SUM_W'(cfg_q.oe_dly) : '0;
        we_at   = cs_at + SUM_W'(cfg_q.we_on);
        we_end  = (first ? SUM_W'(cfg_q.first_wait) : SUM_W'(cfg_q.burst_wait))
                  + SUM_W'(1) - SUM_W'(cfg_q.we_off);
        we_win  = (u >= we_at) && (u < we_end);
    end

    // Chip select and its drive enable.
    always_comb begin
        cs_n  = !(active && (u >= cs_at));
        cs_oe = active || holding ||
                (((phase == PH_IDLE) || (phase == PH_DONE)) && keep_live);
    end

    // Read output enable, write/byte enables, last flag, data drive.
    always_comb begin
        oe_n     = !(active && !write_q && (u >= oe_at));
        we_low   = active && (cfg_q.be_mode || (write_q && we_win));
        we_n     = we_low ? ~lanes_q : '1;
        last     = active && on_last;
        wdata_oe = write_q && (active || holding);
    end

    AST_CS_DRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> cs_oe); // R1
    AST_OE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !cs_n); // R3
    AST_READ_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !write_q && !cfg_q.be_mode) |-> (&we_n)); // R5
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        holding |-> (cs_n && oe_n && (&we_n) && !last && cs_oe)); // R9
endmodule

// File: rtl/burst_strobe_seq.sv
// Top of the burst peripheral bus timing sequencer: accepts a request when
// idle and the timing fields are consistent, then drives the peripheral
// strobes for one single or wrapping burst transfer.
// Assumes: one bank; data capture and packing live elsewhere.
module burst_strobe_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LANES      = 4,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W     = $clog2(LINE_WORDS),
    localparam int CNT_W     = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CD_W-1:0]   cfg_cs_dly,
    input  logic [OD_W-1:0]   cfg_oe_dly,
    input  logic [FW_W-1:0]   cfg_first_wait,
    input  logic [BW_W-1:0]   cfg_burst_wait,
    input  logic [WN_W-1:0]   cfg_we_on,
    input  logic [WF_W-1:0]   cfg_we_off,
    input  logic [TH_W-1:0]   cfg_hold,
    input  logic              cfg_be_mode,
    input  logic              cfg_cs_keep,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_lanes,
    input  logic [CNT_W-1:0]  req_beats,
    input  logic [IDX_W-1:0]  req_crit,
    output logic [ADDR_W-1:0] pb_addr,
    output logic              pb_addr_oe,
    output logic              pb_cs_n,
    output logic              pb_cs_oe,
    output logic              pb_oe_n,
    output logic [LANES-1:0]  pb_we_n,
    output logic              pb_last,
    output logic              pb_wdata_oe,
    output logic              xfer_done,
    output logic              cfg_err
);
    timing_t          cfg_live;
    timing_t          cfg_q;
    phase_e           phase;
    logic [IDX_W-1:0] beat;
    logic [FW_W-1:0]  off;
    logic             first;
    logic             on_last;
    logic             write_q;
    logic [LANES-1:0] lanes_q;
    logic             start;

    // Gather the live timing fields into one record.
    always_comb begin
        cfg_live.cs_dly     = cfg_cs_dly;
        cfg_live.oe_dly     = cfg_oe_dly;
        cfg_live.first_wait = cfg_first_wait;
        cfg_live.burst_wait = cfg_burst_wait;
        cfg_live.we_on      = cfg_we_on;
        cfg_live.we_off     = cfg_we_off;
        cfg_live.hold       = cfg_hold;
        cfg_live.be_mode    = cfg_be_mode;
        cfg_live.cs_keep    = cfg_cs_keep;
    end

    bseq_cfg_check u_check (
        .cfg (cfg_live),
        .bad (cfg_err)
    );

    // Acceptance handshake and done pulse.
    always_comb begin
        req_ready = (phase == PH_IDLE) && !cfg_err;
        start     = req_valid && req_ready;
        xfer_done = (phase == PH_DONE);
    end

    bseq_phase_ctrl #(.LANES(LANES), .LINE_WORDS(LINE_WORDS)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cfg_in   (cfg_live),
        .write_in (req_write),
        .lanes_in (req_lanes),
        .beats_in (req_beats),
        .phase    (phase),
        .beat     (beat),
        .off      (off),
        .first    (first),
        .on_last  (on_last),
        .cfg_q    (cfg_q),
        .write_q  (write_q),
        .lanes_q  (lanes_q)
    );

    bseq_addr_gen #(.ADDR_W(ADDR_W), .LANES(LANES), .LINE_WORDS(LINE_WORDS)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .base_in (req_addr),
        .crit_in (req_crit),
        .phase   (phase),
        .beat    (beat),
        .addr    (pb_addr),
        .addr_oe (pb_addr_oe)
    );

    bseq_strobe_gen #(.LANES(LANES)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .off       (off),
        .first     (first),
        .on_last   (on_last),
        .cfg_q     (cfg_q),
        .keep_live (cfg_cs_keep),
        .write_q   (write_q),
        .lanes_q   (lanes_q),
        .cs_n      (pb_cs_n),
        .cs_oe     (pb_cs_oe),
        .oe_n      (pb_oe_n),
        .we_n      (pb_we_n),
        .last      (pb_last),
        .wdata_oe  (pb_wdata_oe)
    );

    AST_NO_START_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_IDLE) && cfg_err) |=> (phase == PH_IDLE)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done); // R11
    AST_LAST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        pb_last |-> (pb_addr_oe && !xfer_done)); // R8
endmodule

// File: tb/sim_burst_strobe_seq.sv
// Directed bench for the burst peripheral bus timing sequencer.
module sim_burst_strobe_seq;
    localparam int ADDR_W = 32;
    localparam int LANES  = 4;
    localparam int LW     = 8;
    localparam int IW     = 3;
    localparam int BB     = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_cs_dly = '0, cfg_oe_dly = '0, cfg_we_on = '0, cfg_we_off = '0;
    logic [4:0] cfg_first_wait = 5'd3;
    logic [2:0] cfg_burst_wait = '0, cfg_hold = '0;
    logic cfg_be_mode = 1'b0, cfg_cs_keep = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LANES-1:0] req_lanes = '0;
    logic [IW:0] req_beats = '0;
    logic [IW-1:0] req_crit = '0;
    logic req_ready, pb_addr_oe, pb_cs_n, pb_cs_oe, pb_oe_n, pb_last, pb_wdata_oe;
    logic xfer_done, cfg_err;
    logic [ADDR_W-1:0] pb_addr;
    logic [LANES-1:0] pb_we_n;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    burst_strobe_seq #(.ADDR_W(ADDR_W), .LANES(LANES), .LINE_WORDS(LW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_cs_dly(cfg_cs_dly), .cfg_oe_dly(cfg_oe_dly),
        .cfg_first_wait(cfg_first_wait), .cfg_burst_wait(cfg_burst_wait),
        .cfg_we_on(cfg_we_on), .cfg_we_off(cfg_we_off), .cfg_hold(cfg_hold),
        .cfg_be_mode(cfg_be_mode), .cfg_cs_keep(cfg_cs_keep),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_lanes(req_lanes), .req_beats(req_beats),
        .req_crit(req_crit),
        .pb_addr(pb_addr), .pb_addr_oe(pb_addr_oe), .pb_cs_n(pb_cs_n),
        .pb_cs_oe(pb_cs_oe), .pb_oe_n(pb_oe_n), .pb_we_n(pb_we_n),
        .pb_last(pb_last), .pb_wdata_oe(pb_wdata_oe),
        .xfer_done(xfer_done), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_cfg(input int cd, od, fw, bw, wn, wf, th, bem, keep);
        cfg_cs_dly = 2'(cd); cfg_oe_dly = 2'(od); cfg_first_wait = 5'(fw);
        cfg_burst_wait = 3'(bw); cfg_we_on = 2'(wn); cfg_we_off = 2'(wf);
        cfg_hold = 3'(th); cfg_be_mode = 1'(bem); cfg_cs_keep = 1'(keep);
    endtask

    // One transfer, compared every cycle against the requirement timing.
    // Called at a negedge with the block idle; returns at the first idle negedge.
    task automatic run_txn(input bit wr, input int lanes, input int beats,
                           input int crit, input int base, input bit change_mid);
        int cd = cfg_cs_dly, od = cfg_oe_dly, fw = cfg_first_wait, bw = cfg_burst_wait;
        int wn = cfg_we_on, wf = cfg_we_off, th = cfg_hold;
        bit bem = cfg_be_mode;
        int b = (beats == 0) ? 1 : ((beats > LW) ? LW : beats);    // R13
        int len = (fw + 1) + (b - 1) * (bw + 1);
        req_valid = 1'b1; req_write = wr; req_lanes = 4'(lanes);
        req_beats = 4'(beats); req_crit = 3'(crit); req_addr = base;
        chk("R11 ready before start", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c <= len + th + 1; c++) begin
            bit act = (c < len);
            bit hld = (c >= len) && (c < len + th);
            bit dn  = (c == len + th);
            int k = 0, u = 0, p = fw + 1, on = 0, offl = 0;
            logic [31:0] ea, ewe;
            if (act && c > fw) begin
                k = 1 + (c - fw - 1) / (bw + 1);
                u = (c - fw - 1) % (bw + 1);
                p = bw + 1;
            end else if (act) begin
                u = c;
            end
            if (hld) k = b - 1;
            ea = (base & ~((1 << (BB + IW)) - 1)) | (((crit + k) % LW) << BB);
            on = wn + ((k == 0) ? cd : 0);
            offl = p - wf;
            ewe = 32'hF;
            if (act && bem) ewe = {28'd0, ~4'(lanes)};
            else if (act && wr && u >= on && u < offl) ewe = {28'd0, ~4'(lanes)};
            chk("R9 address drive", {31'd0, pb_addr_oe}, {31'd0, act || hld});
            if (act || hld) chk("R4 beat address", pb_addr, ea);
            chk("R1 chip select", {31'd0, pb_cs_n}, {31'd0, !(act && c >= cd)});
            chk("R2 chip select drive", {31'd0, pb_cs_oe},
                {31'd0, act || hld || (!act && !hld && cfg_cs_keep)});
            chk("R3 output enable", {31'd0, pb_oe_n}, {31'd0, !(act && !wr && c >= cd + od)});
            chk(bem ? "R7 byte enables" : ((k == 0) ? "R5 first-beat write enables"
                                                     : "R6 later-beat write enables"),
                {28'd0, pb_we_n}, ewe);
            chk("R8 last flag", {31'd0, pb_last}, {31'd0, act && (k == b - 1)});
            chk("R9 write data drive", {31'd0, pb_wdata_oe}, {31'd0, wr && (act || hld)});
            chk("R11 done pulse", {31'd0, xfer_done}, {31'd0, dn});
            if (c == len + th + 1)
                chk("R11 ready after done", {31'd0, req_ready}, {31'd0, !cfg_err});
            if (change_mid && c == 1)
                set_cfg(0, 3, 20, 7, 3, 0, 5, !bem, cfg_cs_keep);  // R12 disturb
            if (c < len + th + 1) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R11 reset ready", {31'd0, req_ready}, 32'd1);
        chk("R9 reset address undriven", {31'd0, pb_addr_oe}, 32'd0);
        chk("R1 reset chip select", {31'd0, pb_cs_n}, 32'd1);
        chk("R2 reset chip select undriven", {31'd0, pb_cs_oe}, 32'd0);
        chk("R5 reset enables", {28'd0, pb_we_n}, 32'hF);
        chk("R11 reset done", {31'd0, xfer_done}, 32'd0);
    endtask

    task automatic t_single_read;
        set_cfg(1, 2, 6, 3, 1, 1, 2, 0, 0);
        run_txn(1'b0, 4'hF, 1, 5, 32'h1000_0040, 1'b0);
    endtask

    task automatic t_burst_write_wrap;
        set_cfg(2, 0, 5, 3, 1, 1, 1, 0, 0);
        run_txn(1'b1, 4'b0110, 4, 6, 32'h2000_0080, 1'b0);
    endtask

    task automatic t_burst_read_bytemode;
        set_cfg(1, 1, 4, 2, 1, 0, 0, 1, 1);
        run_txn(1'b0, 4'b1010, 8, 3, 32'h3000_0100, 1'b0);
    endtask

    task automatic t_write_bytemode;
        set_cfg(1, 0, 8, 5, 3, 2, 3, 1, 1);
        run_txn(1'b1, 4'b0011, 2, 7, 32'h4000_0000, 1'b0);
    endtask

    task automatic t_float_release;
        set_cfg(0, 0, 3, 0, 0, 0, 0, 0, 0);
        run_txn(1'b1, 4'b1111, 0, 2, 32'h5000_0020, 1'b0);   // R13 zero count
        set_cfg(0, 0, 2, 1, 0, 0, 0, 0, 0);
        run_txn(1'b0, 4'b1111, 15, 1, 32'h5000_0060, 1'b0);  // R13 over-long count
    endtask

    task automatic t_cfg_error;
        set_cfg(2, 1, 2, 3, 0, 0, 0, 0, 0);
        req_valid = 1'b1; req_beats = 4'd1;
        repeat (4) begin
            @(negedge clk);
            chk("R10 first-wait error flag", {31'd0, cfg_err}, 32'd1);
            chk("R10 refused", {31'd0, req_ready}, 32'd0);
            chk("R10 no address", {31'd0, pb_addr_oe}, 32'd0);
            chk("R10 no chip select", {31'd0, pb_cs_n}, 32'd1);
        end
        set_cfg(0, 0, 9, 1, 1, 1, 0, 0, 0);
        @(negedge clk);
        chk("R10 burst-wait error flag", {31'd0, cfg_err}, 32'd1);
        chk("R10 no address", {31'd0, pb_addr_oe}, 32'd0);
        req_valid = 1'b0;
        set_cfg(0, 0, 9, 2, 1, 1, 0, 0, 0);
        @(negedge clk);
        chk("R10 error clears", {31'd0, cfg_err}, 32'd0);
    endtask

    task automatic t_mid_change;
        set_cfg(2, 1, 7, 4, 2, 1, 2, 0, 0);
        run_txn(1'b1, 4'b1001, 3, 7, 32'h6000_0000, 1'b1);   // R12
        set_cfg(1, 1, 6, 3, 1, 1, 1, 0, 0);
        run_txn(1'b0, 4'b1111, 2, 0, 32'h6000_0100, 1'b1);   // R12
    endtask

    task automatic t_back_to_back;
        set_cfg(0, 0, 1, 1, 0, 0, 0, 0, 1);
        run_txn(1'b1, 4'b0101, 2, 4, 32'h7000_0000, 1'b0);
        run_txn(1'b0, 4'b1111, 3, 1, 32'h7000_0040, 1'b0);   // R11 no gap
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_read();
        t_burst_write_wrap();
        t_burst_read_bytemode();
        t_write_bytemode();
        t_float_release();
        t_cfg_error();
        t_mid_change();
        t_back_to_back();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule